// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a serial-bus slave that sits in front of a small bank of 16-bit control registers. The host runs four-wire SPI in mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge). Each transaction is a fixed 24-bit word that carries a direction flag, a 6-bit register address and a 16-bit data field. The slave samples the serial pins with its own system clock, so the serial clock has to be several times slower than that clock.

Writes land only when chip select rises after exactly 24 clock pulses. Reads return the addressed register in the same transaction. Register 0x00 holds a fixed identity code and two control bits: a stored parity-enable flag and a soft-reset bit that clears and holds every other register. Register 0x01 collects sticky error flags for short frames, long frames and accesses to addresses that do not exist. Registers 0x02 to 0x0B, except 0x06, drive a flat parallel bus that downstream logic decodes.

Top module: `spi_regfile_slave`

## Requirements
- R1: A frame is 24 bits, sent MSB first on MOSI. Bit 23 set means read and clear means write. Bits 22:17 are the address, bits 16:1 are data, and bit 0 is ignored. A write to register a (0x02..0x0B, not 0x06) takes effect when CS_N rises after exactly 24 SCLK rising edges, and appears on `cfg_o[16*(a-2) +: 16]`. The bus changes only at the end of a frame.
- R2: In a read frame the slave returns the addressed register on MISO in frame bits 16:1 of the same frame. MISO is 0 during bits 23:17, during bit 0 and while CS_N is high.
- R3: Register 0x00 reads as {parity-enable, soft-reset, 2'b00, 8-bit chip identifier 0x09, 4-bit revision (default 0x1)}. The identifier, revision and bits 13:12 ignore writes. Bit 15 is stored and appears on `par_en_o`.
- R4: Writing register 0x00 with bit 14 set clears registers 0x02..0x0B and the alarm register. They stay at 0, ignoring writes and not recording alarms, until register 0x00 is written with bit 14 clear.
- R5: A frame with fewer than 24 SCLK rising edges, including none, commits nothing and sets alarm bit 14.
- R6: A frame with more than 24 SCLK rising edges commits nothing and sets alarm bit 13.
- R7: A 24-bit frame addressed to 0x06 or above 0x0B sets alarm bit 12. A write to such an address is dropped, and a read of it returns 0.
- R8: Register 0x01 reads as {alarm[3:0], 12'b0}, with bit 15 for parity, bit 14 for too few, bit 13 for too many and bit 12 for range. Alarm bits are sticky and clear at the end of a 24-bit read of 0x01. Writes to 0x01 are ignored. Bit 15 is never set.
- R9: After reset, all registers read 0 apart from the identity fields, `cfg_o` is 0, `par_en_o` is 0 and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, mode 0 |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| cfg_o | output | 160 | Registers 0x02..0x0B, 16 bits each; the slot for 0x06 is always 0 |
| par_en_o | output | 1 | Stored parity-enable bit of register 0x00 |

## Verification
The bench sends frames that stop short of 24 bits or run past it, and then checks that no register moved and that the matching alarm bit reads back. A slave that committed on a bit count instead of on chip-select rise would corrupt registers on long frames. A read is timed so that data bit 16 is already on MISO before the eighth rising edge; an off-by-one shift would return every value doubled or halved. Soft reset is exercised while held, with writes attempted and then a release, to catch a design that clears only once. Reads of the address gap and of addresses past the top catch a decoder that aliases them onto real storage.

// File: rtl/spi_rf_pkg.sv
// Shared constants, frame type and address helper for the serial register slave.
package spi_rf_pkg;
    localparam int DW         = 16;
    localparam int AW         = 6;
    localparam int FRAME_BITS = 1 + AW + DW + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int CFG_BASE   = 2;
    localparam int PAR_BIT    = 15;
    localparam int SRST_BIT   = 14;
    localparam int NALM       = 4;

    localparam logic [AW-1:0] ADDR_CTRL  = 6'h00;
    localparam logic [AW-1:0] ADDR_ALARM = 6'h01;
    localparam logic [AW-1:0] ADDR_HOLE  = 6'h06;
    localparam logic [AW-1:0] ADDR_LAST  = 6'h0B;
    localparam int NCFG = int'(ADDR_LAST) - CFG_BASE + 1;

    localparam logic [CNT_W-1:0] CNT_PEEK  = CNT_W'(AW);
    localparam logic [CNT_W-1:0] CNT_SHIFT = CNT_W'(AW + 1);
    localparam logic [CNT_W-1:0] CNT_STORE = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER  = CNT_W'(FRAME_BITS + 1);

    typedef struct packed {
        logic             rd;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic [CNT_W-1:0] nbits;
    } frame_t;

    function automatic logic addr_ok(input logic [AW-1:0] a);
        return (a <= ADDR_LAST) && (a != ADDR_HOLE);
    endfunction
endpackage

// File: rtl/spi_rf_frame_rx.sv
// Serial front end: synchronises the serial pins, counts SCLK rising edges,
// captures the frame and shifts read data out on falling edges.
// Assumes SCLK half-period spans at least SYNC_STAGES+2 system clocks.
module spi_rf_frame_rx
    import spi_rf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] peek_addr,
    output logic          frm_done,
    output frame_t        frm,
    output logic          miso
);
    logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, mosi_sr;
    logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
    logic rise, fall, cs_fall;
    logic [FRAME_BITS-2:0] sh;
    logic [CNT_W-1:0]      cnt;
    logic [DW:0]           tx;

    // Bring the asynchronous serial pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_sr <= '0;
            cs_sr   <= '1;
            mosi_sr <= '0;
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
            cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
            mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
            sclk_d  <= sclk_s;
            cs_d    <= cs_s;
        end
    end

    assign sclk_s  = sclk_sr[SYNC_STAGES-1];
    assign cs_s    = cs_sr[SYNC_STAGES-1];
    assign mosi_s  = mosi_sr[SYNC_STAGES-1];
    assign rise    = sclk_s & ~sclk_d & ~cs_s;
    assign fall    = ~sclk_s & sclk_d & ~cs_s;
    assign cs_fall = ~cs_s & cs_d;

    // Shift in frame bits 23..1, count edges, load and shift read data.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_fall) begin
            sh  <= '0;
            cnt <= '0;
            tx  <= '0;
        end else if (rise) begin
            if (cnt < CNT_STORE) sh <= {sh[FRAME_BITS-3:0], mosi_s};
            if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
            if (cnt == CNT_PEEK) tx <= sh[AW-1] ? {rd_data, 1'b0} : '0;
        end else if (fall && cnt > CNT_SHIFT) begin
            tx <= {tx[DW-1:0], 1'b0};
        end
    end

    assign peek_addr = {sh[AW-2:0], mosi_s};
    assign frm_done  = cs_s & ~cs_d;
    assign frm.rd    = sh[FRAME_BITS-2];
    assign frm.addr  = sh[FRAME_BITS-3 -: AW];
    assign frm.data  = sh[DW-1:0];
    assign frm.nbits = cnt;
    assign miso      = tx[DW] & ~cs_s;
endmodule

// File: rtl/spi_rf_bank.sv
// Register storage: identity/control word, sticky alarms and the
// configuration registers; commits frames at chip-select rise.
// Assumes frm is valid in the cycle frm_done is high.
module spi_rf_bank
    import spi_rf_pkg::*;
#(
    parameter logic [7:0] CHIP_ID = 8'h09,
    parameter logic [3:0] REV_ID  = 4'h1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_done,
    input  frame_t             frm,
    input  logic [AW-1:0]      peek_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NCFG*DW-1:0] cfg_o,
    output logic               par_en_o,
    output logic               srst_o,
    output logic [NALM-1:0]    alarm_o
);
    logic            exact, wr_ok, ctrl_wr, clear_all;
    logic            few, many, range_err, alm_clr;
    logic            par_q, srst_q;
    logic [NALM-1:0] alarm_q;
    logic [DW-1:0]   cfg_q [NCFG];

    assign exact     = frm_done && (frm.nbits == CNT_FULL);
    assign wr_ok     = exact && !frm.rd && addr_ok(frm.addr);
    assign ctrl_wr   = wr_ok && (frm.addr == ADDR_CTRL);
    assign clear_all = (ctrl_wr && frm.data[SRST_BIT]) || srst_q;
    assign few       = frm_done && (frm.nbits < CNT_FULL);
    assign many      = frm_done && (frm.nbits > CNT_FULL);
    assign range_err = exact && !addr_ok(frm.addr);
    assign alm_clr   = exact && frm.rd && (frm.addr == ADDR_ALARM);

    // Control word: stored parity-enable and soft-reset bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q  <= 1'b0;
            srst_q <= 1'b0;
        end else if (ctrl_wr) begin
            par_q  <= frm.data[PAR_BIT];
            srst_q <= frm.data[SRST_BIT];
        end
    end

    // Sticky alarm flags, cleared by reading them or by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_all) alarm_q <= '0;
        else alarm_q <= (alm_clr ? '0 : alarm_q) | {1'b0, few, many, range_err};
    end

    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
        if (AW'(CFG_BASE + i) == ADDR_HOLE) begin : g_hole
            assign cfg_q[i] = '0;
        end else begin : g_reg
            // One configuration register, written by an exact frame to its address.
            always_ff @(posedge clk) begin
                if (!rst_n || clear_all) cfg_q[i] <= '0;
                else if (wr_ok && frm.addr == AW'(CFG_BASE + i)) cfg_q[i] <= frm.data;
            end
        end
        assign cfg_o[i*DW +: DW] = cfg_q[i];
    end

    // Read multiplexer addressed by the early-captured address.
    always_comb begin
        rd_data = '0;
        if (peek_addr == ADDR_CTRL) rd_data = {par_q, srst_q, 2'b00, CHIP_ID, REV_ID};
        else if (peek_addr == ADDR_ALARM) rd_data = {alarm_q, {(DW-NALM){1'b0}}};
        else begin
            for (int i = 0; i < NCFG; i++)
                if (peek_addr == AW'(CFG_BASE + i)) rd_data = cfg_q[i];
        end
    end

    assign par_en_o = par_q;
    assign srst_o   = srst_q;
    assign alarm_o  = alarm_q;
endmodule

// File: rtl/spi_regfile_slave.sv
// Top level: serial front end plus register bank.
// Assumes mode 0 serial timing and SCLK well below the clk rate.
module spi_regfile_slave
    import spi_rf_pkg::*;
#(
    parameter logic [7:0] CHIP_ID     = 8'h09,
    parameter logic [3:0] REV_ID      = 4'h1,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    output logic               miso,
    output logic [NCFG*DW-1:0] cfg_o,
    output logic               par_en_o
);
    logic            frm_done;
    frame_t          frm;
    logic [AW-1:0]   peek_addr;
    logic [DW-1:0]   rd_data;
    logic            srst_q;
    logic [NALM-1:0] alarm_q;

    spi_rf_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .rd_data(rd_data), .peek_addr(peek_addr), .frm_done(frm_done),
        .frm(frm), .miso(miso)
    );

    spi_rf_bank #(.CHIP_ID(CHIP_ID), .REV_ID(REV_ID)) u_bank (
        .clk(clk), .rst_n(rst_n), .frm_done(frm_done), .frm(frm),
        .peek_addr(peek_addr), .rd_data(rd_data), .cfg_o(cfg_o),
        .par_en_o(par_en_o), .srst_o(srst_q), .alarm_o(alarm_q)
    );
endmodule

// File: rtl/spi_regfile_chk.sv
// Property checker for the register slave, bound into the top module.
module spi_regfile_chk
    import spi_rf_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               done,
    input logic               srst,
    input logic [NALM-1:0]    alarm,
    input logic [NCFG*DW-1:0] cfg
);
    localparam int HOLE = int'(ADDR_HOLE) - CFG_BASE;

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cfg[HOLE*DW +: DW] == '0); // R7
    AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) srst |-> (cfg == '0 && alarm == '0)); // R4
    AST_CFG_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(cfg)); // R1
    AST_NO_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n) alarm[NALM-1] == 1'b0); // R8
    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !done |=> ((alarm & $past(alarm)) == $past(alarm))); // R8
endmodule

bind spi_regfile_slave spi_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .done(frm_done), .srst(srst_q),
    .alarm(alarm_q), .cfg(cfg_o)
);

// File: tb/sim_spi_regfile_slave.sv
`timescale 1ns/1ps
module sim_spi_regfile_slave;
    import spi_rf_pkg::*;

    localparam int HALF = 40;
    localparam int GAP  = 160;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, par_en_o;
    logic [NCFG*DW-1:0] cfg_o;
    int checks = 0, fails = 0;
    bit finished = 0;

    logic [DW-1:0] m_cfg [NCFG];
    logic [3:0]    m_alm;
    logic          m_par, m_srst;

    always #2.5 clk = ~clk;

    spi_regfile_slave u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .cfg_o(cfg_o), .par_en_o(par_en_o)
    );

    function automatic logic [23:0] mk(input logic rd, input logic [5:0] a, input logic [15:0] d);
        return {rd, a, d, 1'b0};
    endfunction

    function automatic logic m_ok(input logic [5:0] a);
        return (a <= 6'h0B) && (a != 6'h06);
    endfunction

    function automatic logic [15:0] m_read(input logic [5:0] a);
        if (a == 6'h00) return {m_par, m_srst, 2'b00, 8'h09, 4'h1};
        if (a == 6'h01) return {m_alm, 12'h000};
        if (!m_ok(a)) return 16'h0000;
        return m_cfg[a - 6'd2];
    endfunction

    function automatic logic [NCFG*DW-1:0] m_flat();
        logic [NCFG*DW-1:0] v;
        for (int i = 0; i < NCFG; i++) v[i*DW +: DW] = m_cfg[i];
        return v;
    endfunction

    task automatic check(input string tag, input logic [NCFG*DW-1:0] act, input logic [NCFG*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] f, input int nb, output logic [23:0] r);
        r = '0;
        cs_n = 1'b0;
        #(HALF);
        for (int i = 0; i < nb; i++) begin
            mosi = (i < 24) ? f[23-i] : 1'b0;
            #(HALF);
            sclk = 1'b1;
            r = {r[22:0], miso};
            #(HALF);
            sclk = 1'b0;
        end
        #(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        #(GAP);
    endtask

    // Reference update per frame, derived from the requirements.
    task automatic model(input logic [23:0] f, input int nb);
        logic [5:0] a = f[22:17];
        logic [15:0] d = f[16:1];
        logic old = m_srst, set_now = 1'b0;
        if (nb < 24) m_alm[2] = 1'b1;
        else if (nb > 24) m_alm[1] = 1'b1;
        else if (!m_ok(a)) m_alm[0] = 1'b1;
        else if (f[23]) begin
            if (a == 6'h01) m_alm = '0;
        end else if (a == 6'h00) begin
            m_par = d[15];
            m_srst = d[14];
            set_now = d[14];
        end else if (a != 6'h01) m_cfg[a - 6'd2] = d;
        if (set_now || old) begin
            for (int i = 0; i < NCFG; i++) m_cfg[i] = '0;
            m_alm = '0;
        end
    endtask

    task automatic frame(input logic [23:0] f, input int nb);
        logic [23:0] r;
        logic [15:0] exp = m_read(f[22:17]);
        string tag;
        xfer(f, nb, r);
        if (nb == 24 && f[23]) begin
            tag = (f[22:17] == 6'h00) ? "R3" : (f[22:17] == 6'h01) ? "R8" : !m_ok(f[22:17]) ? "R7" : "R2";
            check(tag, {136'd0, r[16:1]}, {136'd0, exp});
            check("R2 idle bits", {136'd0, r[23:17], r[0]}, '0);
        end
        model(f, nb);
        check("R1 cfg bus", cfg_o, m_flat());
        check("R3 par_en", {159'd0, par_en_o}, {159'd0, m_par});
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        logic [23:0] r;
        xfer(mk(1'b1, a, 16'h0), 24, r);
        check(tag, {144'd0, r[16:1]}, {144'd0, exp});
        model(mk(1'b1, a, 16'h0), 24);
    endtask

    initial begin
        for (int i = 0; i < NCFG; i++) m_cfg[i] = '0;
        m_alm = '0; m_par = 1'b0; m_srst = 1'b0;
        void'($urandom(32'd1234));
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        #(GAP);
        // R9: reset state
        check("R9 cfg", cfg_o, '0);
        check("R9 miso/par", {158'd0, miso, par_en_o}, '0);
        rd_chk("R9 alarm", 6'h01, 16'h0000);
        // R3: identity and read-only fields
        rd_chk("R3 id", 6'h00, 16'h0091);
        frame(mk(1'b0, 6'h00, 16'hBFFF), 24);
        rd_chk("R3 ro fields", 6'h00, 16'h8091);
        frame(mk(1'b0, 6'h00, 16'h0000), 24);
        // R1/R2: write and read back at the top and bottom of the map
        frame(mk(1'b0, 6'h02, 16'hA5C3), 24);
        frame(mk(1'b0, 6'h0B, 16'hFFFF), 24);
        rd_chk("R2 low", 6'h02, 16'hA5C3);
        rd_chk("R2 high", 6'h0B, 16'hFFFF);
        // R7: gap and above-range addresses
        frame(mk(1'b0, 6'h06, 16'h1357), 24);
        rd_chk("R7 gap read", 6'h06, 16'h0000);
        rd_chk("R7 alarm", 6'h01, 16'h1000);
        rd_chk("R8 cleared", 6'h01, 16'h0000);
        frame(mk(1'b0, 6'h3F, 16'h2468), 24);
        frame(mk(1'b0, 6'h01, 16'hFFFF), 24);
        rd_chk("R8 write ignored", 6'h01, 16'h1000);
        // R5: short frame
        frame(mk(1'b0, 6'h03, 16'hABCD), 20);
        rd_chk("R5 no commit", 6'h03, 16'h0000);
        frame(mk(1'b0, 6'h03, 16'hABCD), 0);
        rd_chk("R5 alarm", 6'h01, 16'h4000);
        // R6: long frame
        frame(mk(1'b0, 6'h04, 16'h4321), 28);
        rd_chk("R6 no commit", 6'h04, 16'h0000);
        rd_chk("R6 alarm", 6'h01, 16'h2000);
        // R4: soft reset held, then released
        frame(mk(1'b0, 6'h05, 16'h1234), 24);
        frame(mk(1'b0, 6'h00, 16'h4000), 24);
        check("R4 cleared", cfg_o, '0);
        frame(mk(1'b0, 6'h05, 16'h5555), 24);
        rd_chk("R4 held", 6'h05, 16'h0000);
        frame(mk(1'b0, 6'h00, 16'h0000), 24);
        frame(mk(1'b0, 6'h05, 16'h5555), 24);
        rd_chk("R4 released", 6'h05, 16'h5555);
        // Random traffic against the reference model
        for (int n = 0; n < 60; n++) begin
            logic [5:0] a = 6'($urandom % 14);
            logic [15:0] d = 16'($urandom);
            int k = $urandom % 10;
            int nb = (k == 0) ? 21 : (k == 1) ? 26 : 24;
            if (a == 6'h00 && ($urandom % 6) != 0) d[14] = 1'b0;
            frame(mk(1'($urandom), a, d), nb);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule